// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This block moves 32-bit words between an attached storage device and system memory without processor help. Software builds a chain of 16-byte descriptors in memory, programs the chain's base address and the address of a completion area through a small 32-bit register file, selects a direction and sets the start bit. The engine then fetches each descriptor, streams that buffer word by word between its memory request port and its device data handshake, and follows the chain until it reaches the descriptor flagged as last.

After the last buffer has been moved, the engine fills the completion area with all-ones words. Software polls this area, so it can see that every data write has landed even when register reads and memory writes are not ordered. Separate byte counters on the device side and the memory side let software compare the two after a run. A stop request ends a run cleanly at the next word boundary. A memory error response ends it with a sticky fault flag and an interrupt line.

Top module: `dma_sg_top`

## Requirements
- R1: After reset the control/status word reads 0, both interrupt outputs are low and no memory request is raised.
- R2: Registers sit at word indices 0 timing, 1 chain base low, 2 chain base high, 3 current buffer address, 4 current address high (always 0), 5 device byte count, 6 memory byte count, 7 control/status, 8 completion-area address. Indices 0, 1, 2 and 8 read back the value written.
- R3: Control/status bit 0 is start (reads 0), bit 1 stop, bit 2 direction, bit 3 active, bit 4 fault. A write while idle stores the direction. A read-modify-write that adds bit 0 keeps the stored direction.
- R4: A descriptor is four 32-bit words, each stored with its most significant byte first. Word 1 is the buffer byte address. Word 3 bits 15:0 are the byte length and bit 31 marks the last descriptor. Descriptors are read from the chain base in steps of 16 bytes.
- R5: With direction 0 the engine reads memory words from the buffer address upward and presents each one, in order, on the device write port.
- R6: With direction 1 each word taken from the device read port is written to memory at ascending buffer addresses.
- R7: A descriptor with length 0 moves no data, and the engine goes on to the next descriptor.
- R8: After the last descriptor's data, the engine writes 32 all-ones words at ascending addresses from the completion-area address. Active then clears and the done interrupt rises. The done interrupt clears on the next control write while idle.
- R9: Both byte counters clear at start and advance by 4 for each word moved on their own side.
- R10: A start written while active is ignored: the direction and the transfer position are unchanged.
- R11: A stop written while active reads back as 1 until the engine quiesces at the next word boundary. Stop and active then clear, with no completion writes and no done interrupt. A stop written while idle is ignored.
- R12: A stop written during the completion writes takes no effect until they finish: all 32 marker words are written, done rises, and the stop bit clears.
- R13: An error memory response sets the fault bit, clears active and raises the error interrupt. A control write while idle clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regIdx | input | 4 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regIdx (combinational) |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | Request is a write |
| memReqAddr | output | 32 | Request byte address |
| memReqWdata | output | 32 | Write data |
| memRspValid | input | 1 | Response for the single outstanding request |
| memRspData | input | 32 | Read response data |
| memRspErr | input | 1 | Response carries an error |
| devRdValid | input | 1 | Device offers a word |
| devRdReady | output | 1 | Engine takes the offered word |
| devRdData | input | 32 | Word from the device |
| devWrValid | output | 1 | Engine offers a word to the device |
| devWrReady | input | 1 | Device takes the word |
| devWrData | output | 32 | Word to the device |
| irqDone | output | 1 | Run completed (level) |
| irqErr | output | 1 | Fault flag (level) |

## Verification
Two functions can fall in the same run: a software stop request and the completion-marker burst. The bench watches the memory request address and writes stop just as the third marker word goes out. This puts a pending stop beside a burst that must not be cut short. The scoreboard must then receive all 32 marker writes in order, and afterwards done must be high and the stop bit must read 0. A second case writes stop while the device holds off a word in mid-transfer. There the stop bit must read 1 for exactly the quiescing cycle, and no marker word may appear.

// File: rtl/dma_sg_pkg.sv
package dma_sg_pkg;

  localparam logic [3:0] RIX_TIMING  = 4'd0;
  localparam logic [3:0] RIX_CHAINLO = 4'd1;
  localparam logic [3:0] RIX_CHAINHI = 4'd2;
  localparam logic [3:0] RIX_CURLO   = 4'd3;
  localparam logic [3:0] RIX_CURHI   = 4'd4;
  localparam logic [3:0] RIX_DEVCNT  = 4'd5;
  localparam logic [3:0] RIX_MEMCNT  = 4'd6;
  localparam logic [3:0] RIX_CTRL    = 4'd7;
  localparam logic [3:0] RIX_MARK    = 4'd8;

  localparam int CB_GO    = 0;
  localparam int CB_HALT  = 1;
  localparam int CB_DIR   = 2;
  localparam int CB_BUSY  = 3;
  localparam int CB_FAULT = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_ADR_REQ, S_ADR_RSP, S_LEN_REQ, S_LEN_RSP, S_EVAL,
    S_DEV_IN, S_MWR_REQ, S_MWR_RSP, S_MRD_REQ, S_MRD_RSP, S_DEV_OUT,
    S_MARK_REQ, S_MARK_RSP
  } seqState_t;

  typedef enum logic [1:0] {A_DESC_ADR, A_DESC_LEN, A_BUF, A_MARK} addrSel_t;

  typedef struct packed {
    logic     ldAddr;
    logic     ldLen;
    logic     advList;
    logic     wordDone;
    logic     devBeat;
    logic     memBeat;
    logic     bufLoad;
    logic     markBeat;
    logic     setErr;
    logic     setDone;
    logic     endRun;
    addrSel_t addrSel;
  } strobe_t;

  function automatic logic [31:0] swapBytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/dma_sg_datapath.sv
module dma_sg_datapath
  import dma_sg_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int MARK_BYTES = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  regIdx,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        busy,
  input  strobe_t     stb,
  input  logic [31:0] memRspData,
  input  logic [31:0] devRdData,
  output logic        startPulse,
  output logic        stopPend,
  output logic        dirD2M,
  output logic        remZero,
  output logic        eolFlag,
  output logic        markLast,
  output logic        errFlag,
  output logic        doneFlag,
  output logic [31:0] memReqAddr,
  output logic [31:0] memReqWdata,
  output logic [31:0] devWrData
);

  localparam int WORD_BYTES  = 4;
  localparam int DESC_BYTES  = 16;
  localparam int MARK_WORDS  = MARK_BYTES / WORD_BYTES;
  localparam int MARK_CNT_W  = (MARK_WORDS > 1) ? $clog2(MARK_WORDS) : 1;

  logic [31:0] timingReg, chainLo, chainHi, markBase;
  logic [31:0] chainCur, curAddr, devCount, memCount, dataBuf;
  logic [LEN_W-1:0] remLen;
  logic [MARK_CNT_W-1:0] markCnt;
  logic [31:0] rspSwapped;
  logic ctrlWr;
  logic unusedLenBits;

  assign rspSwapped    = swapBytes(memRspData);
  assign unusedLenBits = ^rspSwapped[30:LEN_W];
  assign ctrlWr        = regWrEn && (regIdx == RIX_CTRL);
  assign startPulse    = ctrlWr && regWrData[CB_GO] && !busy;
  assign remZero       = (remLen == '0);
  assign markLast      = (markCnt == MARK_CNT_W'(MARK_WORDS - 1));

  // software-visible configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timingReg <= '0;
      chainLo   <= '0;
      chainHi   <= '0;
      markBase  <= '0;
      dirD2M    <= 1'b0;
      errFlag   <= 1'b0;
      doneFlag  <= 1'b0;
      stopPend  <= 1'b0;
    end else begin
      if (regWrEn && regIdx == RIX_TIMING)  timingReg <= regWrData;
      if (regWrEn && regIdx == RIX_CHAINLO) chainLo   <= regWrData;
      if (regWrEn && regIdx == RIX_CHAINHI) chainHi   <= regWrData;
      if (regWrEn && regIdx == RIX_MARK)    markBase  <= regWrData;
      if (ctrlWr && !busy) begin
        dirD2M   <= regWrData[CB_DIR];
        errFlag  <= 1'b0;
        doneFlag <= 1'b0;
      end
      if (stb.setErr)  errFlag  <= 1'b1;
      if (stb.setDone) doneFlag <= 1'b1;
      if (stb.endRun) stopPend <= 1'b0;
      else if (ctrlWr && busy && regWrData[CB_HALT]) stopPend <= 1'b1;
    end
  end

  // walk state and counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chainCur <= '0;
      curAddr  <= '0;
      remLen   <= '0;
      eolFlag  <= 1'b0;
      devCount <= '0;
      memCount <= '0;
      dataBuf  <= '0;
      markCnt  <= '0;
    end else begin
      if (startPulse) begin
        chainCur <= chainLo;
        devCount <= '0;
        memCount <= '0;
        markCnt  <= '0;
        remLen   <= '0;
      end
      if (stb.advList) chainCur <= chainCur + 32'(DESC_BYTES);
      if (stb.ldAddr)  curAddr  <= rspSwapped;
      if (stb.ldLen) begin
        remLen  <= rspSwapped[LEN_W-1:0];
        eolFlag <= rspSwapped[31];
      end
      if (stb.wordDone) begin
        curAddr <= curAddr + 32'(WORD_BYTES);
        remLen  <= (remLen > LEN_W'(WORD_BYTES)) ? remLen - LEN_W'(WORD_BYTES) : '0;
      end
      if (stb.devBeat) devCount <= devCount + 32'(WORD_BYTES);
      if (stb.memBeat) memCount <= memCount + 32'(WORD_BYTES);
      if (stb.devBeat && dirD2M) dataBuf <= devRdData;
      if (stb.bufLoad) dataBuf <= memRspData;
      if (stb.markBeat) markCnt <= markCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (stb.addrSel)
      A_DESC_ADR: memReqAddr = chainCur + 32'd4;
      A_DESC_LEN: memReqAddr = chainCur + 32'd12;
      A_BUF:      memReqAddr = curAddr;
      default:    memReqAddr = markBase + 32'({markCnt, 2'b00});
    endcase
  end

  assign memReqWdata = (stb.addrSel == A_MARK) ? '1 : dataBuf;
  assign devWrData   = dataBuf;

  always_comb begin
    regRdData = '0;
    unique case (regIdx)
      RIX_TIMING:  regRdData = timingReg;
      RIX_CHAINLO: regRdData = chainLo;
      RIX_CHAINHI: regRdData = chainHi;
      RIX_CURLO:   regRdData = curAddr;
      RIX_CURHI:   regRdData = '0;
      RIX_DEVCNT:  regRdData = devCount;
      RIX_MEMCNT:  regRdData = memCount;
      RIX_CTRL: begin
        regRdData[CB_HALT]  = stopPend;
        regRdData[CB_DIR]   = dirD2M;
        regRdData[CB_BUSY]  = busy;
        regRdData[CB_FAULT] = errFlag;
      end
      RIX_MARK:    regRdData = markBase;
      default:     regRdData = '0;
    endcase
  end

endmodule

// File: rtl/dma_sg_ctrl.sv
module dma_sg_ctrl
  import dma_sg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startPulse,
  input  logic    stopPend,
  input  logic    dirD2M,
  input  logic    remZero,
  input  logic    eolFlag,
  input  logic    markLast,
  input  logic    memReqReady,
  input  logic    memRspValid,
  input  logic    memRspErr,
  input  logic    devRdValid,
  input  logic    devWrReady,
  output strobe_t stb,
  output logic    busy,
  output logic    marking,
  output logic    memReqValid,
  output logic    memReqWrite,
  output logic    devRdReady,
  output logic    devWrValid
);

  seqState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy    = (state != S_IDLE);
  assign marking = (state == S_MARK_REQ) || (state == S_MARK_RSP);

  always_comb begin
    nxt         = state;
    stb         = '0;
    stb.addrSel = A_BUF;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    devRdReady  = 1'b0;
    devWrValid  = 1'b0;
    unique case (state)
      S_IDLE: if (startPulse) nxt = S_ADR_REQ;
      S_ADR_REQ: begin
        stb.addrSel = A_DESC_ADR;
        memReqValid = 1'b1;
        if (memReqReady) nxt = S_ADR_RSP;
      end
      S_ADR_RSP: begin
        stb.addrSel = A_DESC_ADR;
        if (memRspValid) begin
          if (memRspErr) begin
            stb.setErr = 1'b1; stb.endRun = 1'b1; nxt = S_IDLE;
          end else begin
            stb.ldAddr = 1'b1; nxt = S_LEN_REQ;
          end
        end
      end
      S_LEN_REQ: begin
        stb.addrSel = A_DESC_LEN;
        memReqValid = 1'b1;
        if (memReqReady) nxt = S_LEN_RSP;
      end
      S_LEN_RSP: begin
        stb.addrSel = A_DESC_LEN;
        if (memRspValid) begin
          if (memRspErr) begin
            stb.setErr = 1'b1; stb.endRun = 1'b1; nxt = S_IDLE;
          end else begin
            stb.ldLen = 1'b1; nxt = S_EVAL;
          end
        end
      end
      S_EVAL: begin
        if (stopPend) begin
          stb.endRun = 1'b1; nxt = S_IDLE;
        end else if (remZero) begin
          if (eolFlag) nxt = S_MARK_REQ;
          else begin
            stb.advList = 1'b1; nxt = S_ADR_REQ;
          end
        end else if (dirD2M) nxt = S_DEV_IN;
        else nxt = S_MRD_REQ;
      end
      S_DEV_IN: begin
        if (stopPend) begin
          stb.endRun = 1'b1; nxt = S_IDLE;
        end else begin
          devRdReady = 1'b1;
          if (devRdValid) begin
            stb.devBeat = 1'b1; nxt = S_MWR_REQ;
          end
        end
      end
      S_MWR_REQ: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) nxt = S_MWR_RSP;
      end
      S_MWR_RSP: begin
        if (memRspValid) begin
          if (memRspErr) begin
            stb.setErr = 1'b1; stb.endRun = 1'b1; nxt = S_IDLE;
          end else begin
            stb.memBeat = 1'b1; stb.wordDone = 1'b1; nxt = S_EVAL;
          end
        end
      end
      S_MRD_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nxt = S_MRD_RSP;
      end
      S_MRD_RSP: begin
        if (memRspValid) begin
          if (memRspErr) begin
            stb.setErr = 1'b1; stb.endRun = 1'b1; nxt = S_IDLE;
          end else begin
            stb.memBeat = 1'b1; stb.bufLoad = 1'b1; nxt = S_DEV_OUT;
          end
        end
      end
      S_DEV_OUT: begin
        if (stopPend) begin
          stb.endRun = 1'b1; nxt = S_IDLE;
        end else begin
          devWrValid = 1'b1;
          if (devWrReady) begin
            stb.devBeat = 1'b1; stb.wordDone = 1'b1; nxt = S_EVAL;
          end
        end
      end
      S_MARK_REQ: begin
        stb.addrSel = A_MARK;
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) nxt = S_MARK_RSP;
      end
      S_MARK_RSP: begin
        stb.addrSel = A_MARK;
        if (memRspValid) begin
          if (memRspErr) begin
            stb.setErr = 1'b1; stb.endRun = 1'b1; nxt = S_IDLE;
          end else begin
            stb.markBeat = 1'b1;
            if (markLast) begin
              stb.setDone = 1'b1; stb.endRun = 1'b1; nxt = S_IDLE;
            end else nxt = S_MARK_REQ;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/dma_sg_top.sv
module dma_sg_top
  import dma_sg_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int MARK_BYTES = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  regIdx,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic        memReqWrite,
  output logic [31:0] memReqAddr,
  output logic [31:0] memReqWdata,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  input  logic        memRspErr,
  input  logic        devRdValid,
  output logic        devRdReady,
  input  logic [31:0] devRdData,
  output logic        devWrValid,
  input  logic        devWrReady,
  output logic [31:0] devWrData,
  output logic        irqDone,
  output logic        irqErr
);

  strobe_t stb;
  logic busy, marking, startPulse, stopPend, dirD2M, remZero, eolFlag, markLast;
  logic errFlag, doneFlag;

  dma_sg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPend(stopPend),
    .dirD2M(dirD2M), .remZero(remZero), .eolFlag(eolFlag), .markLast(markLast),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspErr(memRspErr),
    .devRdValid(devRdValid), .devWrReady(devWrReady), .stb(stb), .busy(busy),
    .marking(marking), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .devRdReady(devRdReady), .devWrValid(devWrValid)
  );

  dma_sg_datapath #(.LEN_W(LEN_W), .MARK_BYTES(MARK_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy), .stb(stb),
    .memRspData(memRspData), .devRdData(devRdData), .startPulse(startPulse),
    .stopPend(stopPend), .dirD2M(dirD2M), .remZero(remZero), .eolFlag(eolFlag),
    .markLast(markLast), .errFlag(errFlag), .doneFlag(doneFlag),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata), .devWrData(devWrData)
  );

  assign irqDone = doneFlag;
  assign irqErr  = errFlag;

endmodule

// File: rtl/dma_sg_chk.sv
module dma_sg_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        marking,
  input logic        stopPend,
  input logic        irqDone,
  input logic        irqErr,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic        memReqWrite,
  input logic [31:0] memReqAddr,
  input logic [31:0] memReqWdata,
  input logic        memRspValid,
  input logic        memRspErr,
  input logic        devWrValid,
  input logic        devWrReady,
  input logic [31:0] devWrData
);

  // R1
  req_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqWrite));

  // R5
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    devWrValid && !devWrReady |=> (devWrValid || stopPend) && $stable(devWrData));

  // R8
  mark_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && marking |-> memReqWrite && (memReqWdata == 32'hFFFF_FFFF));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqDone) |-> !busy);

  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !stopPend);

  // R13
  err_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && memRspValid && memRspErr |=> irqErr && !busy);

endmodule

bind dma_sg_top dma_sg_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .marking(marking), .stopPend(stopPend),
  .irqDone(irqDone), .irqErr(irqErr), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
  .memReqWdata(memReqWdata), .memRspValid(memRspValid), .memRspErr(memRspErr),
  .devWrValid(devWrValid), .devWrReady(devWrReady), .devWrData(devWrData)
);

// File: tb/sim_dma_sg_top.sv
module sim_dma_sg_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regIdx = 4'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic memReqValid, memReqWrite;
  logic memReqReady = 1'b1;
  logic [31:0] memReqAddr, memReqWdata;
  logic memRspValid = 1'b0, memRspErr = 1'b0;
  logic [31:0] memRspData = '0;
  logic devRdValid, devRdReady, devWrValid;
  logic devWrReady = 1'b1;
  logic [31:0] devRdData, devWrData;
  logic irqDone, irqErr;

  dma_sg_top u0 (.*);

  int tests = 0;
  int fails = 0;

  // memory model: one-cycle response, addresses with bit 15 set answer with an error
  logic [31:0] mem [0:511];
  logic slowMem = 1'b0;
  always @(posedge clk) begin
    if (!rstN) begin
      memRspValid <= 1'b0;
      memRspErr   <= 1'b0;
      memReqReady <= 1'b1;
    end else begin
      memRspValid <= 1'b0;
      memRspErr   <= 1'b0;
      if (memReqValid && memReqReady) begin
        memRspValid <= 1'b1;
        if (memReqAddr[15]) memRspErr <= 1'b1;
        else if (memReqWrite) mem[memReqAddr[10:2]] <= memReqWdata;
        else memRspData <= mem[memReqAddr[10:2]];
      end
      memReqReady <= slowMem ? ~memReqReady : 1'b1;
    end
  end

  // device source
  logic [31:0] srcWords [0:15];
  int srcCount = 0;
  int srcIdx = 0;
  assign devRdValid = (srcIdx < srcCount);
  assign devRdData  = srcWords[srcIdx[3:0]];
  always @(posedge clk) if (devRdValid && devRdReady) srcIdx <= srcIdx + 1;

  // scoreboard
  typedef struct {
    bit          isMem;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } item_t;
  item_t expQ[$];

  task automatic pushItem(input bit isMem, input logic [31:0] a, input logic [31:0] d, input string tag);
    item_t it;
    it.isMem = isMem; it.addr = a; it.data = d; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic scoreOne(input bit isMem, input logic [31:0] a, input logic [31:0] d);
    item_t e;
    tests++;
    if (expQ.size() == 0) begin
      fails++;
      $display("FAIL R5 R6 R8 unexpected transfer mem=%0d addr=%h data=%h expected none", isMem, a, d);
    end else begin
      e = expQ.pop_front();
      if (e.isMem != isMem || (isMem && e.addr !== a) || e.data !== d) begin
        fails++;
        $display("FAIL %s act mem=%0d addr=%h data=%h exp mem=%0d addr=%h data=%h",
                 e.tag, isMem, a, d, e.isMem, e.addr, e.data);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (memReqValid && memReqReady && memReqWrite) scoreOne(1'b1, memReqAddr, memReqWdata);
      if (devWrValid && devWrReady) scoreOne(1'b0, 32'h0, devWrData);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] flip(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic regWrite(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regIdx = idx; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    regIdx = idx;
    #1 d = regRdData;
  endtask

  task automatic putDesc(input int at, input logic [31:0] a, input logic [15:0] len, input bit eol);
    mem[at/4]     = '0;
    mem[at/4 + 1] = flip(a);
    mem[at/4 + 2] = '0;
    mem[at/4 + 3] = flip({eol, 15'd0, len});
  endtask

  task automatic clearMark(input int base);
    for (int i = 0; i < 32; i++) mem[base/4 + i] = '0;
  endtask

  task automatic expectMark(input int base);
    for (int i = 0; i < 32; i++) pushItem(1'b1, 32'(base + 4*i), 32'hFFFF_FFFF, "R8");
  endtask

  task automatic waitIdle(output logic [31:0] v);
    for (int i = 0; i < 3000; i++) begin
      regRead(4'd7, v);
      if (!v[3]) break;
    end
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 512; i++) mem[i] = 32'h1000_0000 + 32'(i);
    repeat (5) @(posedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(4'd7, v);
    chk("R1 ctrl", v, 32'h0);
    chk("R1 irqDone", {31'd0, irqDone}, 32'h0);
    chk("R1 irqErr", {31'd0, irqErr}, 32'h0);
    chk("R1 memReqValid", {31'd0, memReqValid}, 32'h0);

    // R2 register file
    regWrite(4'd0, 32'h1234_5678); regRead(4'd0, v); chk("R2 timing", v, 32'h1234_5678);
    regWrite(4'd2, 32'h0000_00A5); regRead(4'd2, v); chk("R2 chain high", v, 32'h0000_00A5);
    regWrite(4'd8, 32'h0000_0400); regRead(4'd8, v); chk("R2 mark addr", v, 32'h0000_0400);
    regRead(4'd4, v); chk("R2 cur high", v, 32'h0);

    // R11 stop while idle ignored
    regWrite(4'd7, 32'h2); regRead(4'd7, v); chk("R11 idle stop", v, 32'h0);

    // memory-to-device with a zero-length descriptor in the chain: R4 R5 R7 R8 R9
    putDesc(32'h100, 32'h200, 16'd8, 1'b0);
    putDesc(32'h110, 32'h300, 16'd0, 1'b0);
    putDesc(32'h120, 32'h208, 16'd4, 1'b1);
    clearMark(32'h400);
    pushItem(1'b0, 0, mem[32'h200/4], "R5");
    pushItem(1'b0, 0, mem[32'h204/4], "R5");
    pushItem(1'b0, 0, mem[32'h208/4], "R7");
    expectMark(32'h400);
    regWrite(4'd1, 32'h100);
    regWrite(4'd8, 32'h400);
    regWrite(4'd7, 32'h0);
    regWrite(4'd7, 32'h1);
    waitIdle(v);
    chk("R8 ctrl after run", v, 32'h0);
    chk("R8 irqDone", {31'd0, irqDone}, 32'h1);
    chk("R4 scoreboard drained", 32'(expQ.size()), 32'h0);
    regRead(4'd5, v); chk("R9 dev count", v, 32'd12);
    regRead(4'd6, v); chk("R9 mem count", v, 32'd12);
    regRead(4'd3, v); chk("R4 cur addr", v, 32'h20C);
    chk("R8 last marker", mem[32'h400/4 + 31], 32'hFFFF_FFFF);
    regWrite(4'd7, 32'h0);
    chk("R8 done cleared", {31'd0, irqDone}, 32'h0);

    // device-to-memory with a stalling memory: R3 R6 R9
    srcWords[0] = 32'hCAFE_0001; srcWords[1] = 32'hCAFE_0002; srcWords[2] = 32'hCAFE_0003;
    srcIdx = 0; srcCount = 3;
    putDesc(32'h140, 32'h280, 16'd12, 1'b1);
    clearMark(32'h480);
    for (int i = 0; i < 3; i++) pushItem(1'b1, 32'(32'h280 + 4*i), srcWords[i], "R6");
    expectMark(32'h480);
    slowMem = 1'b1;
    regWrite(4'd1, 32'h140);
    regWrite(4'd8, 32'h480);
    regWrite(4'd7, 32'h4);
    regRead(4'd7, v); chk("R3 dir stored", v, 32'h4);
    regWrite(4'd7, v | 32'h1);
    waitIdle(v);
    chk("R3 dir kept after rmw start", v, 32'h4);
    chk("R6 word2", mem[32'h288/4], 32'hCAFE_0003);
    chk("R6 scoreboard drained", 32'(expQ.size()), 32'h0);
    regRead(4'd5, v); chk("R9 dev count d2m", v, 32'd12);
    slowMem = 1'b0;

    // start ignored while active, then stop mid-transfer: R10 R11
    devWrReady = 1'b0;
    putDesc(32'h180, 32'h200, 16'd64, 1'b1);
    clearMark(32'h500);
    regWrite(4'd1, 32'h180);
    regWrite(4'd8, 32'h500);
    regWrite(4'd7, 32'h0);
    regWrite(4'd7, 32'h1);
    repeat (20) @(negedge clk);
    regRead(4'd3, v); chk("R10 cur addr before", v, 32'h200);
    regWrite(4'd7, 32'h5);
    regRead(4'd7, v); chk("R10 start ignored", v, 32'h8);
    regRead(4'd3, v); chk("R10 position kept", v, 32'h200);
    regWrite(4'd7, 32'h2);
    regIdx = 4'd7;
    #1 chk("R11 stop pending", regRdData, 32'hA);
    regRead(4'd7, v); chk("R11 stop acked", v, 32'h0);
    chk("R11 no done", {31'd0, irqDone}, 32'h0);
    chk("R11 no marker", mem[32'h500/4], 32'h0);
    devWrReady = 1'b1;

    // stop during the completion burst: R12
    putDesc(32'h1C0, 32'h200, 16'd4, 1'b1);
    clearMark(32'h600);
    pushItem(1'b0, 0, mem[32'h200/4], "R12");
    expectMark(32'h600);
    regWrite(4'd1, 32'h1C0);
    regWrite(4'd8, 32'h600);
    regWrite(4'd7, 32'h1);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (memReqValid && memReqAddr == 32'h608) break;
    end
    regWrite(4'd7, 32'h2);
    waitIdle(v);
    chk("R12 ctrl", v, 32'h0);
    chk("R12 done", {31'd0, irqDone}, 32'h1);
    chk("R12 all markers", 32'(expQ.size()), 32'h0);
    chk("R12 last marker", mem[32'h600/4 + 31], 32'hFFFF_FFFF);

    // memory error: R13
    putDesc(32'h1E0, 32'h8000, 16'd8, 1'b1);
    clearMark(32'h700);
    regWrite(4'd1, 32'h1E0);
    regWrite(4'd8, 32'h700);
    regWrite(4'd7, 32'h1);
    waitIdle(v);
    chk("R13 fault bit", v, 32'h10);
    chk("R13 irqErr", {31'd0, irqErr}, 32'h1);
    chk("R13 no done", {31'd0, irqDone}, 32'h0);
    regWrite(4'd7, 32'h0);
    regRead(4'd7, v); chk("R13 fault cleared", v, 32'h0);
    chk("R13 irqErr cleared", {31'd0, irqErr}, 32'h0);

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule